// File: doc/BRIEF.md
# Shadowed Configuration Register Controller

The block keeps a device's working configuration in nine 28-bit shadow registers, which drive the rest of the device at all times. A nonvolatile word array sits behind them. After the power-up reset the controller reads every stored word into the shadow registers, one word per cycle. When all nine are loaded it raises `cfgValid`.

A host then talks to the block over a four-wire serial port with a latch-enable strobe. Each frame is 32 bits, sent most significant bit first: a 28-bit data field, then a 4-bit code. The block acts on a frame when latch-enable rises. Codes 0 to 8 rewrite a shadow register. Code 0xE arms a read-back for the next frame. Code 0xF carries either a store key or a lock key. A store copies the shadow registers back into the array, one word each time the array is no longer busy, unless the array has been locked. Once set, the lock survives the power-up reset. Only the model reset (`modelRstN`) clears it, and that reset also restores the array's factory words.

A power-down input leaves the configuration untouched and keeps the serial port working. It only raises a hold output for downstream logic.

Top module: `cfgShadowTop`

## Requirements
- R1: While `rstN` is low, `busy` is 1 and `cfgValid`, `storeErr` and `holdOut` are 0. After release, `busy` stays 1 until all nine words have been loaded, and `cfgValid` then goes to 1 and stays there. After a model reset, array word i holds 28'hA0B0C00 + i.
- R2: A frame is 32 bits, sampled on rising edges of `spiClk` while `spiLe` is low. Bits [31:4] are data and bits [3:0] are the code. A code of 0 to 8 writes the data into that shadow register when `spiLe` rises.
- R3: A frame with code 0xE and data[3:0] = n makes the next frame return {register n, n[3:0]} on `spiMiso`, MSB first. The first bit is valid after `spiLe` falls, and each later bit follows a falling edge of `spiClk`. A frame that follows no read request returns all zeros, and `spiMiso` is 0 while `spiLe` is high.
- R4: Code 0xF with data 28'hC0DE5A5 starts a store while the array is unlocked. `busy` is 1 until all nine shadow words have been written to the array, and a later `rstN` pulse reloads those stored words.
- R5: Code 0xF with data 28'hC0DE10C locks the array. A store request made while the array is locked writes nothing, leaves `busy` at 0 and sets a sticky `storeErr`. `rstN` clears `storeErr` but not the lock, and `modelRstN` clears both.
- R6: Frames that complete while `busy` is 1 change no shadow register.
- R7: Codes 0x9 to 0xD, and code 0xF with any data other than the two keys, change neither the registers nor `storeErr`, and do not start a store.
- R8: `holdOut` follows `pwrDn` one clock later. Register writes are still accepted while `pwrDn` is 1.
- R9: `cfgWords[28*i+27:28*i]` always shows shadow register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| modelRstN | input | 1 | Full model reset, active low: restores the array's factory words and clears the lock |
| rstN | input | 1 | Power-up reset, active low: clears the shadow registers and starts the load |
| spiLe | input | 1 | Frame strobe: low while a frame is shifted, rising edge commits it |
| spiClk | input | 1 | Serial clock |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out; read-back data or 0 |
| pwrDn | input | 1 | Power-down request |
| holdOut | output | 1 | Tells downstream logic to hold its outputs |
| busy | output | 1 | A load or store is in progress |
| cfgValid | output | 1 | The shadow registers hold a loaded configuration |
| storeErr | output | 1 | Sticky: a store was requested while the array was locked |
| cfgWords | output | 252 | All nine shadow registers, with register i at bits [28*i+27:28*i] |

## Verification
On every cycle the assertions check the following:
- `cfgValid`, `storeErr` and the lock never fall on their own.
- No array write is issued while the array is busy or locked.
- No host write reaches a shadow register while a load or store runs, or without a completed frame.
- `holdOut` tracks `pwrDn`.

The bench's scenarios cover what the assertions cannot see:
- that stored words really come back after a power-up reset;
- that a locked store leaves the array unchanged;
- that the lock outlives `rstN` but not `modelRstN`;
- that read-back data arrives bit-exact on the following frame.

// File: rtl/cfgShadowPkg.sv
package cfgShadowPkg;
  localparam int NUM_REGS = 9;
  localparam int REG_W    = 28;
  localparam int CODE_W   = 4;
  localparam int FRAME_W  = REG_W + CODE_W;

  localparam logic [CODE_W-1:0] CODE_READ    = 4'hE;
  localparam logic [CODE_W-1:0] CODE_SPECIAL = 4'hF;
  localparam logic [REG_W-1:0]  STORE_KEY    = 28'hC0DE5A5;
  localparam logic [REG_W-1:0]  LOCK_KEY     = 28'hC0DE10C;

  typedef enum logic {SRC_HOST, SRC_NV} shSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              shWr;
    logic [CODE_W-1:0] shIdx;
    shSrc_e            src;
    logic              rdArm;
  } dpStrobe_t;
endpackage

// File: rtl/nvArray.sv
module nvArray #(
  parameter int WORDS    = 9,
  parameter int W        = 28,
  parameter int AW       = 4,
  parameter int WR_LAT   = 40,
  parameter logic [W-1:0] DEF_BASE = 28'hA0B0C00
) (
  input  logic          clk,
  input  logic          modelRstN,
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic [W-1:0]  wdata,
  input  logic          lockSet,
  output logic [W-1:0]  rdata,
  output logic          busy,
  output logic          locked
);
  localparam int CNT_W = $clog2(WR_LAT + 1);

  logic [W-1:0]     mem [WORDS];
  logic [CNT_W-1:0] busyCnt;
  logic             lockQ;

  always_ff @(posedge clk or negedge modelRstN) begin
    if (!modelRstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= DEF_BASE + W'(i);
      busyCnt <= '0;
      lockQ   <= 1'b0;
      rdata   <= '0;
    end else begin
      rdata <= (int'(addr) < WORDS) ? mem[addr] : '0;
      if (wrEn && busyCnt == '0) begin
        if (int'(addr) < WORDS) mem[addr] <= wdata;
        busyCnt <= CNT_W'(WR_LAT);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (lockSet) lockQ <= 1'b1;
    end
  end

  assign busy   = (busyCnt != '0);
  assign locked = lockQ;

  // R4
  wr_while_busy_chk: assert property (@(posedge clk) disable iff (!modelRstN)
    wrEn |-> !busy);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!modelRstN)
    locked |=> locked);
endmodule

// File: rtl/cfgShadowCtl.sv
module cfgShadowCtl
  import cfgShadowPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [CODE_W-1:0] frameCode,
  input  logic [REG_W-1:0]  frameData,
  input  logic              nvBusy,
  input  logic              nvLocked,
  output dpStrobe_t         st,
  output logic [CODE_W-1:0] nvAddr,
  output logic              nvWe,
  output logic              nvLockSet,
  output logic              busy,
  output logic              cfgValid,
  output logic              storeErr
);
  localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(NUM_REGS - 1);

  typedef enum logic [2:0] {S_LOAD, S_LOAD_TAIL, S_IDLE, S_STORE, S_DRAIN} state_e;
  state_e            state;
  logic [CODE_W-1:0] idxQ;
  logic              ldPend;
  logic [CODE_W-1:0] ldIdx;
  logic              hostWr, isSpecial, storeReq;

  assign isSpecial = frameStb && frameCode == CODE_SPECIAL;
  assign storeReq  = isSpecial && frameData == STORE_KEY;
  assign hostWr    = (state == S_IDLE) && frameStb && (frameCode < CODE_W'(NUM_REGS));
  assign nvLockSet = (state == S_IDLE) && isSpecial && frameData == LOCK_KEY;
  assign nvAddr    = idxQ;
  assign nvWe      = (state == S_STORE) && !nvBusy;
  assign busy      = (state != S_IDLE);

  always_comb begin
    st.shWr  = ldPend | hostWr;
    st.shIdx = ldPend ? ldIdx : frameCode;
    st.src   = ldPend ? SRC_NV : SRC_HOST;
    st.rdArm = frameStb && frameCode == CODE_READ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_LOAD;
      idxQ     <= '0;
      ldPend   <= 1'b0;
      ldIdx    <= '0;
      cfgValid <= 1'b0;
      storeErr <= 1'b0;
    end else begin
      case (state)
        S_LOAD: begin
          ldPend <= !nvBusy;
          ldIdx  <= idxQ;
          if (!nvBusy) begin
            idxQ <= idxQ + 1'b1;
            if (idxQ == LAST_IDX) state <= S_LOAD_TAIL;
          end
        end
        S_LOAD_TAIL: begin
          ldPend   <= 1'b0;
          idxQ     <= '0;
          cfgValid <= 1'b1;
          state    <= S_IDLE;
        end
        S_IDLE: begin
          if (storeReq) begin
            if (nvLocked) storeErr <= 1'b1;
            else begin
              idxQ  <= '0;
              state <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (!nvBusy) begin
            idxQ <= idxQ + 1'b1;
            if (idxQ == LAST_IDX) state <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          idxQ <= '0;
          if (!nvBusy) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeErr |=> storeErr);
  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    nvWe |-> !nvLocked);
  // R6
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(st.shWr && st.src == SRC_HOST));
endmodule

// File: rtl/cfgShadowDp.sv
module cfgShadowDp
  import cfgShadowPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      spiLe,
  input  logic                      spiClk,
  input  logic                      spiMosi,
  input  dpStrobe_t                 st,
  input  logic [REG_W-1:0]          nvRdata,
  input  logic [CODE_W-1:0]         storeIdx,
  output logic                      spiMiso,
  output logic                      frameStb,
  output logic [CODE_W-1:0]         frameCode,
  output logic [REG_W-1:0]          frameData,
  output logic [REG_W-1:0]          nvWdata,
  output logic [NUM_REGS*REG_W-1:0] cfgWords
);
  logic               sclkQ, leQ, rdPend;
  logic [CODE_W-1:0]  rdSel;
  logic [FRAME_W-1:0] inShift, frameWord, outShift;
  logic [REG_W-1:0]   shadow [NUM_REGS];
  logic               sclkRise, sclkFall, leRise, leFall;

  assign sclkRise = spiClk & ~sclkQ;
  assign sclkFall = ~spiClk & sclkQ;
  assign leRise   = spiLe & ~leQ;
  assign leFall   = ~spiLe & leQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      leQ       <= 1'b1;
      inShift   <= '0;
      frameWord <= '0;
      frameStb  <= 1'b0;
      outShift  <= '0;
      rdPend    <= 1'b0;
      rdSel     <= '0;
      for (int i = 0; i < NUM_REGS; i++) shadow[i] <= '0;
    end else begin
      sclkQ    <= spiClk;
      leQ      <= spiLe;
      frameStb <= leRise;
      if (!spiLe && sclkRise) inShift <= {inShift[FRAME_W-2:0], spiMosi};
      if (leRise) frameWord <= inShift;
      if (leFall) begin
        if (rdPend && int'(rdSel) < NUM_REGS) outShift <= {shadow[rdSel], rdSel};
        else outShift <= '0;
      end else if (!spiLe && sclkFall) begin
        outShift <= {outShift[FRAME_W-2:0], 1'b0};
      end
      if (frameStb) begin
        rdPend <= st.rdArm;
        if (st.rdArm) rdSel <= frameData[CODE_W-1:0];
      end
      if (st.shWr && int'(st.shIdx) < NUM_REGS)
        shadow[st.shIdx] <= (st.src == SRC_NV) ? nvRdata : frameData;
    end
  end

  assign frameCode = frameWord[CODE_W-1:0];
  assign frameData = frameWord[FRAME_W-1:CODE_W];
  assign spiMiso   = ~spiLe & outShift[FRAME_W-1];
  assign nvWdata   = (int'(storeIdx) < NUM_REGS) ? shadow[storeIdx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gWords
    assign cfgWords[g*REG_W +: REG_W] = shadow[g];
  end

  // R2
  host_wr_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.shWr && st.src == SRC_HOST) |-> frameStb);
endmodule

// File: rtl/cfgShadowTop.sv
module cfgShadowTop
  import cfgShadowPkg::*;
#(
  parameter int WR_LAT = 40,
  parameter logic [REG_W-1:0] DEF_BASE = 28'hA0B0C00
) (
  input  logic                      clk,
  input  logic                      modelRstN,
  input  logic                      rstN,
  input  logic                      spiLe,
  input  logic                      spiClk,
  input  logic                      spiMosi,
  output logic                      spiMiso,
  input  logic                      pwrDn,
  output logic                      holdOut,
  output logic                      busy,
  output logic                      cfgValid,
  output logic                      storeErr,
  output logic [NUM_REGS*REG_W-1:0] cfgWords
);
  dpStrobe_t         st;
  logic              frameStb, nvWe, nvLockSet, nvBusy, nvLocked;
  logic [CODE_W-1:0] frameCode, nvAddr;
  logic [REG_W-1:0]  frameData, nvRdata, nvWdata;

  cfgShadowCtl uCtl (
    .clk, .rstN, .frameStb, .frameCode, .frameData, .nvBusy, .nvLocked,
    .st, .nvAddr, .nvWe, .nvLockSet, .busy, .cfgValid, .storeErr
  );

  cfgShadowDp uDp (
    .clk, .rstN, .spiLe, .spiClk, .spiMosi, .st, .nvRdata,
    .storeIdx(nvAddr), .spiMiso, .frameStb, .frameCode, .frameData,
    .nvWdata, .cfgWords
  );

  nvArray #(
    .WORDS(NUM_REGS), .W(REG_W), .AW(CODE_W), .WR_LAT(WR_LAT), .DEF_BASE(DEF_BASE)
  ) uNv (
    .clk, .modelRstN, .addr(nvAddr), .wrEn(nvWe), .wdata(nvWdata),
    .lockSet(nvLockSet), .rdata(nvRdata), .busy(nvBusy), .locked(nvLocked)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdOut <= 1'b0;
    else       holdOut <= pwrDn;
  end

  // R8
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |=> holdOut);
endmodule

// File: tb/cfgShadowTop_test.sv
module cfgShadowTop_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam logic [27:0] STORE_K = 28'hC0DE5A5;
  localparam logic [27:0] LOCK_K  = 28'hC0DE10C;

  logic clk = 1'b0, modelRstN = 1'b0, rstN = 1'b0;
  logic spiLe = 1'b1, spiClk = 1'b0, spiMosi = 1'b0, pwrDn = 1'b0;
  logic spiMiso, holdOut, busy, cfgValid, storeErr;
  logic [251:0] cfgWords;

  int vecs = 0, errs = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic [31:0] rxWord;
  event rxEv;

  cfgShadowTop uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [27:0] defWord(int i);
    return 28'hA0B0C00 + 28'(i);
  endfunction

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [31:0] w, input bit cap);
    logic [31:0] rx;
    spiLe = 1'b0;
    tick(HALF);
    for (int i = 31; i >= 0; i--) begin
      spiMosi = w[i];
      tick(HALF);
      rx[i] = spiMiso;
      spiClk = 1'b1;
      tick(HALF);
      spiClk = 1'b0;
    end
    tick(HALF);
    spiLe = 1'b1;
    tick(2*HALF);
    if (cap) begin
      rxWord = rx;
      ->rxEv;
      tick(1);
    end
  endtask

  task automatic writeReg(input int idx, input logic [27:0] val);
    sendFrame({val, 4'(idx)}, 1'b0);
  endtask

  task automatic readReg(input int idx, input logic [27:0] exp, input string tag);
    expQ.push_back({exp, 4'(idx)});
    tagQ.push_back(tag);
    sendFrame({24'h0, 4'(idx), 4'hE}, 1'b0);
    sendFrame({28'h0, 4'h9}, 1'b1);
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 5000) begin
      tick(1);
      n++;
    end
    if (busy) check(1'b0, {tag, " busy stuck"}, 32'(busy), 32'h0);
  endtask

  task automatic pulseRst();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rxEv);
      if (expQ.size() == 0) check(1'b0, "monitor unexpected word", rxWord, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rxWord == e, t, rxWord, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    tick(3);
    // R1 reset state
    check(busy == 1'b1, "R1 busy in reset", 32'(busy), 32'h1);
    check(cfgValid == 1'b0, "R1 cfgValid in reset", 32'(cfgValid), 32'h0);
    check(storeErr == 1'b0, "R1 storeErr in reset", 32'(storeErr), 32'h0);
    check(holdOut == 1'b0, "R1 holdOut in reset", 32'(holdOut), 32'h0);
    check(spiMiso == 1'b0, "R3 miso idle", 32'(spiMiso), 32'h0);
    modelRstN = 1'b1;
    rstN = 1'b1;
    tick(2);
    check(busy == 1'b1 && cfgValid == 1'b0, "R1 loading", {30'h0, busy, cfgValid}, 32'h2);
    waitIdle("R1");
    check(cfgValid == 1'b1, "R1 cfgValid after load", 32'(cfgValid), 32'h1);
    for (int i = 0; i < 9; i++) readReg(i, defWord(i), "R1 default word");
    check(cfgWords[4*28 +: 28] == defWord(4), "R9 cfgWords slice 4",
          32'(cfgWords[4*28 +: 28]), 32'(defWord(4)));

    // R2 host writes
    writeReg(3, 28'h1234567);
    writeReg(8, 28'hFEDCBA9);
    readReg(3, 28'h1234567, "R2 write reg3");
    readReg(8, 28'hFEDCBA9, "R2 write reg8");
    check(cfgWords[8*28 +: 28] == 28'hFEDCBA9, "R9 cfgWords slice 8",
          32'(cfgWords[8*28 +: 28]), 32'h0FEDCBA9);

    // R3 no request -> zeros
    expQ.push_back(32'h0);
    tagQ.push_back("R3 unrequested frame");
    sendFrame({28'h0, 4'h9}, 1'b1);

    // R7 ignored codes
    sendFrame({28'h5555555, 4'hA}, 1'b0);
    sendFrame({28'h1111111, 4'hF}, 1'b0);
    check(busy == 1'b0 && storeErr == 1'b0, "R7 no store or error",
          {30'h0, busy, storeErr}, 32'h0);
    readReg(3, 28'h1234567, "R7 reg3 unchanged");

    // R4 store, R6 write while busy
    sendFrame({STORE_K, 4'hF}, 1'b0);
    check(busy == 1'b1, "R4 busy during store", 32'(busy), 32'h1);
    writeReg(0, 28'h0000BAD);
    check(busy == 1'b1, "R6 still busy at write", 32'(busy), 32'h1);
    waitIdle("R4");
    readReg(0, defWord(0), "R6 write during busy ignored");
    writeReg(3, 28'h7777777);
    pulseRst();
    waitIdle("R4 reload");
    readReg(3, 28'h1234567, "R4 stored reg3 reloaded");
    readReg(8, 28'hFEDCBA9, "R4 stored reg8 reloaded");

    // R5 lock
    sendFrame({LOCK_K, 4'hF}, 1'b0);
    sendFrame({STORE_K, 4'hF}, 1'b0);
    check(storeErr == 1'b1, "R5 storeErr on locked store", 32'(storeErr), 32'h1);
    check(busy == 1'b0, "R5 no store when locked", 32'(busy), 32'h0);
    writeReg(3, 28'h2222222);
    pulseRst();
    tick(1);
    check(storeErr == 1'b0, "R5 rstN clears storeErr", 32'(storeErr), 32'h0);
    waitIdle("R5");
    readReg(3, 28'h1234567, "R5 locked array unchanged");
    sendFrame({STORE_K, 4'hF}, 1'b0);
    check(storeErr == 1'b1, "R5 lock survives rstN", 32'(storeErr), 32'h1);

    // R5 model reset clears lock and restores defaults
    modelRstN = 1'b0;
    rstN = 1'b0;
    tick(3);
    modelRstN = 1'b1;
    rstN = 1'b1;
    waitIdle("R5 model reset");
    readReg(3, defWord(3), "R5 defaults after model reset");
    sendFrame({STORE_K, 4'hF}, 1'b0);
    check(busy == 1'b1 && storeErr == 1'b0, "R5 store allowed after model reset",
          {30'h0, busy, storeErr}, 32'h2);
    waitIdle("R5 store");

    // R8 power-down
    pwrDn = 1'b1;
    tick(2);
    check(holdOut == 1'b1, "R8 holdOut high", 32'(holdOut), 32'h1);
    writeReg(5, 28'hABCDEF0);
    readReg(5, 28'hABCDEF0, "R8 write during power-down");
    pwrDn = 1'b0;
    tick(2);
    check(holdOut == 1'b0, "R8 holdOut low", 32'(holdOut), 32'h0);

    tick(5);
    check(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule